// File: doc/BRIEF.md
# Supply and Bus-Activity Reset Supervisor

This block drives the active-low system reset of a chip. Two things pull reset low: the main supply being reported bad, and a watchdog that expires because the two-wire bus has gone quiet. The main supply arrives as a digital good flag. When that flag comes back, reset stays low until the flag has been steady for a power-up delay. The watchdog is restarted only by a bus start condition, which is a falling SDA while SCL is high, sensed on the raw bus lines after synchronisation. When the watchdog expires, it produces a reset pulse of fixed length, and the period then begins again.

A second supply flag is passed straight to its own active-low fail output. It has no delay and does not touch the main reset. A bus inhibit flag tells the bus slave to drop any transfer in progress and refuse new ones while reset is active. The slave may still finish a nonvolatile write that has already started. All durations count an external millisecond tick, so a simulation can shorten them through parameters.

Top module: `supv_reset_ctrl`

## Requirements
- R1: From the asynchronous reset, and while `vcc_ok` is low, `reset_n` is 0. It goes to 1 only after `vcc_ok` has been 1 for POR_TICKS consecutive ticks.
- R2: A low `vcc_ok` drives `reset_n` to 0 within two clock cycles. The power-up count then restarts from zero, so a short glitch delays release by a full POR_TICKS.
- R3: The `wd_sel` code sets the watchdog period. 2'b00 gives LONG_TICKS, 2'b01 gives MID_TICKS, 2'b10 gives SHORT_TICKS, and 2'b11 disables the watchdog, so it never fires.
- R4: Only a start condition restarts the watchdog: SDA going from 1 to 0 while SCL is 1, after a two-flop synchronizer. SDA changes while SCL is 0, and SDA rising while SCL is 1, do not restart it.
- R5: If no start arrives within the selected period, `reset_n` goes to 0 for RST_TICKS ticks. It then returns to 1 and a fresh full period begins.
- R6: Any change of `wd_sel` restarts the watchdog count, so switching to a shorter period never fires early.
- R7: `bus_inhibit` is 1 in every cycle in which `reset_n` is 0.
- R8: `v2fail_n` equals `v2_ok` combinationally in every cycle, including during reset.
- R9: The watchdog count is held at zero while reset is active. After any release, a full period passes before the watchdog can fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| tick | input | 1 | One-cycle time base pulse (nominally 1 ms) |
| vcc_ok | input | 1 | Main supply good flag |
| v2_ok | input | 1 | Second supply good flag |
| scl_raw | input | 1 | Unsynchronised bus clock line |
| sda_raw | input | 1 | Unsynchronised bus data line |
| wd_sel | input | 2 | Watchdog period select (11 = off) |
| reset_n | output | 1 | Active-low system reset |
| v2fail_n | output | 1 | Active-low second-supply fail |
| bus_inhibit | output | 1 | Blocks and aborts bus transfers during reset |

## Verification
The assertions check the cycle-local rules on every cycle. A low supply flag must raise the power-up hold at the next edge. A start or a select change must never coincide with the watchdog starting to fire. A disabled watchdog stays quiet. A firing watchdog or a power-up hold must pull the reset output low. An active reset always carries the inhibit flag. Only the bench's scenarios can show the timing over whole periods. These are the exact release delay after power-up, the restart after a supply glitch, the period chosen by each select code, the length of the expiry pulse, and the fact that stop conditions and data-phase SDA toggles leave the watchdog running to expiry.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_SEL_LONG  = 2'b00,
    WD_SEL_MID   = 2'b01,
    WD_SEL_SHORT = 2'b10,
    WD_SEL_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/sup_start_det.sv
module sup_start_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic start_pulse
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] synced;
  logic             sda_prev_q;

  assign raw_lines = {scl_raw, sda_raw};

  // one synchronizer chain per bus line, idle level high
  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_lines[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev_q <= 1'b1;
    else        sda_prev_q <= synced[0];
  end

  assign start_pulse = synced[1] & sda_prev_q & ~synced[0];

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R4
endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer #(
  parameter int POR_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vcc_ok,
  output logic por_active
);
  localparam int PW = $clog2(POR_TICKS + 1);
  localparam logic [PW-1:0] POR_DONE = PW'(POR_TICKS);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!vcc_ok)                        cnt_d = '0;
    else if (tick && cnt_q != POR_DONE) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign por_active = (cnt_q != POR_DONE);

  AST_POR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> por_active); // R2
  AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_active) |-> ($past(tick) && $past(vcc_ok))); // R1
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200,
  parameter int RST_TICKS   = 250
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    kick,
  input  logic    hold,
  input  wd_sel_e sel,
  output logic    fire
);
  localparam int WD_MAX = (LONG_TICKS > MID_TICKS)
                        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                        : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
  localparam int CW  = $clog2(WD_MAX + 1);
  localparam int RCW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0]  LIM_LONG  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0]  LIM_MID   = CW'(MID_TICKS - 1);
  localparam logic [CW-1:0]  LIM_SHORT = CW'(SHORT_TICKS - 1);
  localparam logic [RCW-1:0] RST_LAST  = RCW'(RST_TICKS - 1);

  wd_sel_e        sel_q;
  logic [CW-1:0]  cnt_q, cnt_d, lim_m1;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           fire_q, fire_d;
  logic           clr, expire;

  always_comb begin
    case (sel)
      WD_SEL_LONG:  lim_m1 = LIM_LONG;
      WD_SEL_MID:   lim_m1 = LIM_MID;
      WD_SEL_SHORT: lim_m1 = LIM_SHORT;
      default:      lim_m1 = '0;
    endcase
  end

  // count held clear during any reset, when off, on start or select change
  assign clr    = hold | fire_q | (sel == WD_SEL_OFF) | kick | (sel != sel_q);
  assign expire = tick & ~clr & (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || expire) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    fire_d = fire_q;
    rcnt_d = rcnt_q;
    if (hold) begin
      fire_d = 1'b0;
      rcnt_d = '0;
    end else if (fire_q) begin
      if (tick) begin
        if (rcnt_q == RST_LAST) begin
          fire_d = 1'b0;
          rcnt_d = '0;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
    end else if (expire) begin
      fire_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= WD_SEL_OFF;
      cnt_q  <= '0;
      rcnt_q <= '0;
      fire_q <= 1'b0;
    end else begin
      sel_q  <= sel;
      cnt_q  <= cnt_d;
      rcnt_q <= rcnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == WD_SEL_OFF && !fire_q) |=> !fire_q); // R3
  AST_KICK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !$rose(fire_q)); // R4
  AST_FIRE_END_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fire_q) && !$past(hold)) |-> $past(tick)); // R5
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |=> !$rose(fire_q)); // R6
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import sup_pkg::*;
#(
  parameter int POR_TICKS   = 200,
  parameter int RST_TICKS   = 250,
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vcc_ok,
  input  logic       v2_ok,
  input  logic       scl_raw,
  input  logic       sda_raw,
  input  logic [1:0] wd_sel,
  output logic       reset_n,
  output logic       v2fail_n,
  output logic       bus_inhibit
);
  logic por_active;
  logic wd_fire;
  logic start_pulse;
  logic sys_rst_q, sys_rst_d;

  sup_start_det #(.STAGES(SYNC_STAGES)) u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_raw     (scl_raw),
    .sda_raw     (sda_raw),
    .start_pulse (start_pulse)
  );

  sup_por_timer #(.POR_TICKS(POR_TICKS)) u_por (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .vcc_ok     (vcc_ok),
    .por_active (por_active)
  );

  sup_watchdog #(
    .LONG_TICKS  (LONG_TICKS),
    .MID_TICKS   (MID_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .RST_TICKS   (RST_TICKS)
  ) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .kick  (start_pulse),
    .hold  (por_active),
    .sel   (wd_sel_e'(wd_sel)),
    .fire  (wd_fire)
  );

  assign sys_rst_d = por_active | wd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_q <= 1'b1;
    else        sys_rst_q <= sys_rst_d;
  end

  assign reset_n     = ~sys_rst_q;
  // raised one cycle ahead of reset_n so no transfer starts at the edge
  assign bus_inhibit = sys_rst_q | sys_rst_d;
  assign v2fail_n    = v2_ok;

  AST_POR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |=> !reset_n); // R1
  AST_FIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> !reset_n); // R5
  AST_INHIBIT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_n |-> bus_inhibit); // R7
endmodule

// File: tb/supv_reset_ctrl_bench.sv
module supv_reset_ctrl_bench;
  localparam int POR = 10;
  localparam int RST = 6;
  localparam int TL  = 40;
  localparam int TM  = 24;
  localparam int TS  = 12;

  logic clk = 1'b0;
  logic rst_n, tick, vcc_ok, v2_ok, scl_raw, sda_raw;
  logic [1:0] wd_sel;
  logic reset_n, v2fail_n, bus_inhibit;

  int n_total = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  supv_reset_ctrl #(
    .POR_TICKS(POR), .RST_TICKS(RST),
    .LONG_TICKS(TL), .MID_TICKS(TM), .SHORT_TICKS(TS)
  ) u_supv_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok), .v2_ok(v2_ok),
    .scl_raw(scl_raw), .sda_raw(sda_raw), .wd_sel(wd_sel),
    .reset_n(reset_n), .v2fail_n(v2fail_n), .bus_inhibit(bus_inhibit)
  );

  // tick on every second cycle
  initial begin
    tick = 1'b0;
    forever @(negedge clk) tick = ~tick;
  end

  function automatic int wd_ticks(input logic [1:0] s);
    case (s)
      2'b00:   return TL;
      2'b01:   return TM;
      2'b10:   return TS;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_level(input logic lvl, input int maxc, output bit found);
    found = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (reset_n == lvl) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  task automatic start_cond();
    scl_raw = 1'b1; sda_raw = 1'b1; cyc(3);
    sda_raw = 1'b0; cyc(3);
    scl_raw = 1'b0; cyc(3);
    sda_raw = 1'b1; cyc(3);
  endtask

  task automatic stop_cond();
    scl_raw = 1'b0; sda_raw = 1'b0; cyc(3);
    scl_raw = 1'b1; cyc(3);
    sda_raw = 1'b1; cyc(3);
  endtask

  task automatic data_wiggle();
    scl_raw = 1'b0;
    for (int i = 0; i < 6; i++) begin
      sda_raw = ~sda_raw;
      cyc(1);
    end
    sda_raw = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    bit found;
    void'($urandom(32'd4242));
    rst_n = 1'b0; vcc_ok = 1'b0; v2_ok = 1'b0;
    scl_raw = 1'b1; sda_raw = 1'b1; wd_sel = 2'b11;
    cyc(5);
    check(reset_n == 1'b0, "R1 reset at power-up", reset_n, 0);
    check(bus_inhibit == 1'b1, "R7 inhibit in reset", bus_inhibit, 1);
    check(v2fail_n == v2_ok, "R8 v2 follow in reset", v2fail_n, v2_ok);
    v2_ok = 1'b1;
    #1 check(v2fail_n == 1'b1, "R8 v2 follow immediate", v2fail_n, 1);
    rst_n = 1'b1;
    cyc(10);
    check(reset_n == 1'b0, "R1 held while vcc low", reset_n, 0);

    // power-up release timing
    vcc_ok = 1'b1;
    cyc(POR*2 - 6);
    check(reset_n == 1'b0, "R1 before power-up delay", reset_n, 0);
    cyc(10);
    check(reset_n == 1'b1, "R1 released after delay", reset_n, 1);

    // supply drop and glitch restart
    vcc_ok = 1'b0;
    cyc(2);
    check(reset_n == 1'b0, "R2 drop asserts reset", reset_n, 0);
    check(bus_inhibit == 1'b1, "R7 inhibit on drop", bus_inhibit, 1);
    vcc_ok = 1'b1; cyc(6);
    vcc_ok = 1'b0; cyc(1);
    vcc_ok = 1'b1;
    cyc(POR*2 - 4);
    check(reset_n == 1'b0, "R2 glitch restarts count", reset_n, 0);
    cyc(10);
    check(reset_n == 1'b1, "R2 release after glitch", reset_n, 1);

    // disabled watchdog
    v2_ok = 1'b0;
    cyc(TL*2*3);
    check(reset_n == 1'b1, "R3 code 11 never fires", reset_n, 1);
    check(v2fail_n == 1'b0, "R8 v2 follow low", v2fail_n, 0);

    // short period, expiry pulse, re-arm
    wd_sel = 2'b10;
    cyc(TS*2 - 6);
    check(reset_n == 1'b1, "R3 short period not yet", reset_n, 1);
    wait_level(1'b0, 14, found);
    check(found, "R3 short period expires", int'(found), 1);
    check(bus_inhibit == 1'b1, "R7 inhibit on expiry", bus_inhibit, 1);
    cyc(RST*2 - 4);
    check(reset_n == 1'b0, "R5 pulse length hold", reset_n, 0);
    cyc(8);
    check(reset_n == 1'b1, "R5 pulse released", reset_n, 1);
    cyc(TS*2 - 10);
    check(reset_n == 1'b1, "R9 full period after release", reset_n, 1);
    wait_level(1'b0, 16, found);
    check(found, "R5 fires again", int'(found), 1);
    wait_level(1'b1, 40, found);

    // starts keep it alive
    for (int k = 0; k < 6; k++) begin
      start_cond();
      cyc(6);
    end
    check(reset_n == 1'b1, "R4 starts prevent expiry", reset_n, 1);
    // stops and data toggles do not kick
    fork
      begin
        for (int k = 0; k < 3; k++) begin
          stop_cond();
          data_wiggle();
        end
      end
      wait_level(1'b0, 60, found);
    join
    check(found, "R4 stop and data edges ignored", int'(found), 1);
    wait_level(1'b1, 40, found);

    // select change restarts the count
    wd_sel = 2'b00;
    cyc(60);
    wd_sel = 2'b01;
    cyc(TM*2 - 8);
    check(reset_n == 1'b1, "R6 change gives full new period", reset_n, 1);
    wait_level(1'b0, 20, found);
    check(found, "R6 new period expires", int'(found), 1);

    // constrained random kicks
    for (int it = 0; it < 10; it++) begin
      int per;
      int nk;
      wait_level(1'b1, 40, found);
      v2_ok = 1'($urandom_range(1, 0));
      wd_sel = 2'($urandom_range(2, 0));
      per = wd_ticks(wd_sel) * 2;
      nk = int'($urandom_range(4, 2));
      #1 check(v2fail_n == v2_ok, "R8 random v2", v2fail_n, v2_ok);
      for (int k = 0; k < nk; k++) begin
        cyc(int'($urandom_range(per - 20, 0)));
        start_cond();
      end
      check(reset_n == 1'b1, "R4 random kicks", reset_n, 1);
      cyc(per - 14);
      check(reset_n == 1'b1, "R3 random period not yet", reset_n, 1);
      wait_level(1'b0, 30, found);
      check(found, "R3 random period expires", int'(found), 1);
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule